// File: doc/BRIEF.md
# Load/Store Alignment and Byte-Order Unit

This unit sits between the address/data path of a load/store stage and a 32-bit data memory port. For each request it checks that the access is aligned for its size (byte, halfword or word). For ordinary loads it picks the addressed bytes out of the memory word, orders them under a selectable byte order, and sign- or zero-extends the value. For stores it forms the byte-lane enables. Ordinary loads and stores at misaligned addresses are not serviced. Instead a fault is raised so that the pipeline can trap.

A word at an unaligned address is read with a pair of merge loads that use the same address. The left-part merge and the right-part merge each overwrite part of an incoming register value with the memory bytes they cover. Once both have run, the register holds the full unaligned word. Requests carry a valid strobe, and every result appears on the registered outputs one clock after it is presented.

Top module: `lsu_align_unit`

## Requirements
- R1: After reset, `out_valid`, `result`, `byte_en` and `misalign` are all zero.
- R2: A request presented with `in_valid` high produces `out_valid` high with its results on the next rising clock edge. A cycle with `in_valid` low produces `out_valid` low on the next edge.
- R3: Requests use the operation codes 00 load, 01 store, 10 load-left and 11 load-right, and the size codes 00 byte, 01 halfword and 1x word. A load or store raises `misalign` when its address is not a multiple of its size: a halfword with address bit 0 set, or a word with address bits [1:0] not 00.
- R4: A faulting request returns `result` = 0 and `byte_en` = 0.
- R5: The memory byte at address offset i (the value of address bits [1:0]) travels on `rdata` bits [8i+7:8i]. Byte enable bit i refers to that same lane.
- R6: A byte or halfword load is sign-extended to 32 bits when `is_signed` is 1 and zero-extended when it is 0.
- R7: With `big_endian` = 1, the lowest-addressed byte of a halfword or word is its most significant byte. With `big_endian` = 0, it is the least significant byte. For example, the memory bytes 00,00,02,03 read as the word 515 in big-endian order.
- R8: An aligned store sets the enables of the lanes it covers: one lane for a byte, lanes k and k+1 for a halfword at offset k, and all four lanes for a word. The enables do not depend on `big_endian`. Loads of every kind return `byte_en` = 0.
- R9: In big-endian order, load-left at offset k writes memory bytes k..3 into register bytes 3 down to k and keeps the lower register bytes. In little-endian order it writes memory bytes 0..k into register bytes 3-k up to 3 and keeps the rest. Register byte j is `merge_val` bits [8j+7:8j].
- R10: In big-endian order, load-right at offset k writes memory bytes k down to 0 into register bytes 0..k and keeps the upper bytes. In little-endian order it writes memory bytes k..3 into register bytes 0..3-k and keeps the rest.
- R11: Load-left and load-right never raise `misalign`, and they ignore `size` and `is_signed`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request strobe |
| addr | input | ADDR_W | Access address |
| size | input | 2 | Access size code |
| is_signed | input | 1 | Sign-extend narrow loads |
| big_endian | input | 1 | 1 selects big-endian byte order |
| op | input | 2 | Operation code |
| rdata | input | DATA_W | Memory word read |
| merge_val | input | DATA_W | Current destination register value |
| out_valid | output | 1 | Result strobe |
| result | output | DATA_W | Load or merge result |
| byte_en | output | DATA_W/8 | Store lane enables |
| misalign | output | 1 | Alignment fault |

## Verification
The unit holds no state across requests apart from its output register. Any error in lane steering, offset mirroring or the masks therefore shows up at the ports one cycle after the request that triggers it, as a wrong `result` byte, `byte_en` pattern or `misalign` value. The bench sweeps every operation, size, offset, byte order and sign setting against an independent model written directly from the rules. It also checks the 515 example in both byte orders. Timing faults are caught by comparing the number of results against the number of requests and by checking that `out_valid` drops after an idle cycle.

// File: rtl/lsu_align_pkg.sv
package lsu_align_pkg;

   typedef enum logic [1:0] {
      OP_LOAD  = 2'b00,
      OP_STORE = 2'b01,
      OP_LDL   = 2'b10,
      OP_LDR   = 2'b11
   } lsu_op_e;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'b00,
      SZ_HALF = 2'b01,
      SZ_WORD = 2'b10
   } lsu_size_e;

   // Merge operations have the top opcode bit set (R11)
   function automatic logic op_is_merge(input logic [1:0] op);
      return op[1];
   endfunction

endpackage

// File: rtl/lsu_align_check.sv
module lsu_align_check
   import lsu_align_pkg::*;
#(
   parameter int LANES = 4,
   localparam int OFF_W = $clog2(LANES)
) (
   input  logic [1:0]       op,
   input  logic [1:0]       size,
   input  logic [OFF_W-1:0] off,
   output logic             fault,
   output logic [LANES-1:0] lane_en
);

   logic             mis;
   logic [LANES-1:0] mask;

   always_comb begin
      if (size[1]) begin
         mis  = |off;
         mask = '1;
      end else if (size[0]) begin
         mis  = off[0];
         mask = LANES'(3) << off;
      end else begin
         mis  = 1'b0;
         mask = LANES'(1) << off;
      end
   end

   // R3: only plain loads and stores are subject to the size check
   assign fault   = !op_is_merge(op) && mis;
   // R8: only aligned stores drive enables
   assign lane_en = (op == OP_STORE && !mis) ? mask : '0;

endmodule

// File: rtl/lsu_lane_swap.sv
module lsu_lane_swap #(
   parameter int DATA_W = 32,
   localparam int LANES = DATA_W / 8
) (
   input  logic              swap,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] dout
);

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      assign dout[8*i +: 8] = swap ? din[8*(LANES-1-i) +: 8] : din[8*i +: 8];
   end

endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract #(
   parameter int DATA_W = 32,
   localparam int LANES = DATA_W / 8,
   localparam int OFF_W = $clog2(LANES)
) (
   input  logic [DATA_W-1:0] data,     // lanes already in little-endian order
   input  logic [OFF_W-1:0]  off,      // offset already mirrored for big-endian
   input  logic [1:0]        size,
   input  logic              sgn,
   output logic [DATA_W-1:0] value
);

   logic [7:0]  b;
   logic [15:0] h;

   assign b = data[{off, 3'b000} +: 8];
   assign h = data[{off[OFF_W-1:1], 4'b0000} +: 16];

   always_comb begin
      if (size[1])
         value = data;
      else if (size[0])
         value = {{(DATA_W-16){sgn & h[15]}}, h};
      else
         value = {{(DATA_W-8){sgn & b[7]}}, b};
   end

endmodule

// File: rtl/lsu_merge.sv
module lsu_merge #(
   parameter int DATA_W = 32,
   localparam int LANES = DATA_W / 8,
   localparam int OFF_W = $clog2(LANES)
) (
   input  logic [DATA_W-1:0] data,     // lanes in little-endian order
   input  logic [OFF_W-1:0]  off,      // offset in little-endian terms
   input  logic              left,
   input  logic [DATA_W-1:0] reg_val,
   output logic [DATA_W-1:0] value
);

   logic [OFF_W+2:0]  sh;
   logic [DATA_W-1:0] keep;
   logic [DATA_W-1:0] mem_part;

   always_comb begin
      if (left) begin
         // memory bytes 0..off fill the top lanes
         sh       = {~off, 3'b000};
         mem_part = data << sh;
         keep     = ~({DATA_W{1'b1}} << sh);
      end else begin
         // memory bytes off..top fill the bottom lanes
         sh       = {off, 3'b000};
         mem_part = data >> sh;
         keep     = ~({DATA_W{1'b1}} >> sh);
      end
      value = mem_part | (reg_val & keep);
   end

endmodule

// File: rtl/lsu_align_unit.sv
module lsu_align_unit
   import lsu_align_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 32,
   localparam int LANES = DATA_W / 8,
   localparam int OFF_W = $clog2(LANES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [ADDR_W-1:0] addr,
   input  logic [1:0]        size,
   input  logic              is_signed,
   input  logic              big_endian,
   input  logic [1:0]        op,
   input  logic [DATA_W-1:0] rdata,
   input  logic [DATA_W-1:0] merge_val,
   output logic              out_valid,
   output logic [DATA_W-1:0] result,
   output logic [LANES-1:0]  byte_en,
   output logic              misalign
);

   if (DATA_W != 32) begin : g_bad_width
      $error("lsu_align_unit: word size is fixed at 32 bits");
   end
   if (ADDR_W < OFF_W) begin : g_bad_addr
      $error("lsu_align_unit: address narrower than lane offset");
   end

   logic [OFF_W-1:0]  off;
   logic              unused_addr_hi;
   logic [OFF_W-1:0]  ext_off;
   logic [OFF_W-1:0]  mrg_off;
   logic [DATA_W-1:0] le_data;
   logic [DATA_W-1:0] ext_val;
   logic [DATA_W-1:0] mrg_val;
   logic              fault_d;
   logic [LANES-1:0]  be_d;
   logic [DATA_W-1:0] result_d;

   assign off            = addr[OFF_W-1:0];
   assign unused_addr_hi = ^addr;

   // Big-endian is handled by reversing lanes and mirroring offsets (R7)
   always_comb begin
      if (!big_endian)
         ext_off = off;
      else if (size[1])
         ext_off = '0;
      else if (size[0])
         ext_off = {~off[OFF_W-1:1], 1'b0};
      else
         ext_off = ~off;
   end
   assign mrg_off = big_endian ? ~off : off;

   lsu_lane_swap #(.DATA_W(DATA_W)) u_swap (
      .swap (big_endian),
      .din  (rdata),
      .dout (le_data)
   );

   lsu_align_check #(.LANES(LANES)) u_check (
      .op      (op),
      .size    (size),
      .off     (off),
      .fault   (fault_d),
      .lane_en (be_d)
   );

   lsu_load_extract #(.DATA_W(DATA_W)) u_extract (
      .data  (le_data),
      .off   (ext_off),
      .size  (size),
      .sgn   (is_signed),
      .value (ext_val)
   );

   lsu_merge #(.DATA_W(DATA_W)) u_merge (
      .data    (le_data),
      .off     (mrg_off),
      .left    (op == OP_LDL),
      .reg_val (merge_val),
      .value   (mrg_val)
   );

   always_comb begin
      unique case (lsu_op_e'(op))
         OP_LOAD:  result_d = fault_d ? '0 : ext_val;
         OP_STORE: result_d = '0;
         default:  result_d = mrg_val;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         result    <= '0;
         byte_en   <= '0;
         misalign  <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            result   <= result_d;
            byte_en  <= be_d;
            misalign <= fault_d;
         end else begin
            byte_en  <= '0;
            misalign <= 1'b0;
         end
      end
   end

   assert_valid_next_R2: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   assert_idle_next_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
   assert_word_fault_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !op[1] && size[1] && addr[1:0] != 2'b00) |=> misalign);
   assert_fault_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
      misalign |-> (byte_en == '0 && result == '0));
   assert_load_no_en_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op != OP_STORE) |=> byte_en == '0);
   assert_byte_store_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op == OP_STORE && size == SZ_BYTE) |=> $countones(byte_en) == 1);
   assert_merge_nofault_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op[1]) |=> !misalign);

endmodule

// File: tb/test_lsu_align_unit.sv
module test_lsu_align_unit;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [31:0] addr = '0;
   logic [1:0]  size = '0;
   logic        is_signed = 1'b0;
   logic        big_endian = 1'b0;
   logic [1:0]  op = '0;
   logic [31:0] rdata = '0;
   logic [31:0] merge_val = '0;
   logic        out_valid;
   logic [31:0] result;
   logic [3:0]  byte_en;
   logic        misalign;

   int tests = 0;
   int fails = 0;
   bit done = 0;

   typedef struct {
      logic [31:0] r;
      logic [3:0]  be;
      logic        f;
      string       tag;
   } exp_t;

   exp_t q[$];

   always #5 clk = ~clk;

   lsu_align_unit i_lsu_align_unit (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .addr(addr), .size(size),
      .is_signed(is_signed), .big_endian(big_endian), .op(op), .rdata(rdata),
      .merge_val(merge_val), .out_valid(out_valid), .result(result),
      .byte_en(byte_en), .misalign(misalign)
   );

   function automatic exp_t model(input logic [1:0] o, input logic [1:0] sz,
                                  input logic sg, input logic bend, input int k,
                                  input logic [31:0] rd, input logic [31:0] mv);
      exp_t e;
      logic [7:0] m[4];
      logic [7:0] rg[4];
      logic [15:0] h;
      for (int i = 0; i < 4; i++) begin
         m[i]  = rd[8*i +: 8];
         rg[i] = mv[8*i +: 8];
      end
      e.r  = '0;
      e.be = '0;
      e.f  = (o < 2) && ((sz == 2'd1 && k[0]) || (sz[1] && k != 0));
      if (o == 2'd1 && !e.f)
         e.be = sz[1] ? 4'hF : (sz[0] ? (4'h3 << k) : (4'h1 << k));
      if (o == 2'd0 && !e.f) begin
         if (sz[1])
            e.r = bend ? {m[0], m[1], m[2], m[3]} : {m[3], m[2], m[1], m[0]};
         else if (sz[0]) begin
            h = bend ? {m[k], m[k+1]} : {m[k+1], m[k]};
            e.r = {{16{sg & h[15]}}, h};
         end else
            e.r = {{24{sg & m[k][7]}}, m[k]};
      end
      if (o >= 2) begin
         for (int j = 0; j < 4; j++) begin
            if (o == 2'd2 && bend)       rg[j] = (j >= k)     ? m[3-j+k] : rg[j];
            else if (o == 2'd2)          rg[j] = (j >= 3-k)   ? m[j-3+k] : rg[j];
            else if (bend)               rg[j] = (j <= k)     ? m[k-j]   : rg[j];
            else                         rg[j] = (j <= 3-k)   ? m[k+j]   : rg[j];
         end
         e.r = {rg[3], rg[2], rg[1], rg[0]};
      end
      if (e.f)             e.tag = "R3 R4";
      else if (o == 2'd1)  e.tag = "R8";
      else if (o == 2'd2)  e.tag = "R9 R11";
      else if (o == 2'd3)  e.tag = "R10 R11";
      else if (!sz[1])     e.tag = "R5 R6 R7";
      else                 e.tag = "R7";
      return e;
   endfunction

   task automatic drive(input logic [1:0] o, input logic [1:0] sz, input logic sg,
                        input logic bend, input logic [31:0] a, input logic [31:0] rd,
                        input logic [31:0] mv, input exp_t e);
      @(negedge clk);
      in_valid   = 1'b1;
      op         = o;
      size       = sz;
      is_signed  = sg;
      big_endian = bend;
      addr       = a;
      rdata      = rd;
      merge_val  = mv;
      q.push_back(e);
   endtask

   task automatic check_now(input bit ok, input string tag, input logic [31:0] act,
                            input logic [31:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // Monitor: pops the oldest expectation whenever a result appears
   always @(negedge clk) begin
      if (rst_n && out_valid) begin
         exp_t e;
         tests++;
         if (q.size() == 0) begin
            fails++;
            $display("FAIL R2 unexpected out_valid actual=1 expected=0");
         end else begin
            e = q.pop_front();
            if (result !== e.r || byte_en !== e.be || misalign !== e.f) begin
               fails++;
               $display("FAIL %s actual r=%h be=%h f=%b expected r=%h be=%h f=%b",
                        e.tag, result, byte_en, misalign, e.r, e.be, e.f);
            end
         end
      end
   end

   initial begin
      exp_t e;
      repeat (2) @(negedge clk);
      // R1: reset state
      check_now(out_valid === 1'b0 && result === '0 && byte_en === '0 && misalign === 1'b0,
                "R1 reset", {result[31:6], byte_en, out_valid, misalign}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);

      // R7: bytes 00,00,02,03 in address order read as 515
      e = '{r: 32'd515, be: 4'h0, f: 1'b0, tag: "R7 big 515"};
      drive(2'd0, 2'd2, 1'b0, 1'b1, 32'h100, 32'h0302_0000, 32'h0, e);
      e = '{r: 32'd515, be: 4'h0, f: 1'b0, tag: "R7 little 515"};
      drive(2'd0, 2'd2, 1'b0, 1'b0, 32'h100, 32'h0000_0203, 32'h0, e);
      // R6: sign versus zero extension of a negative byte
      e = '{r: 32'hFFFF_FF80, be: 4'h0, f: 1'b0, tag: "R6 signed byte"};
      drive(2'd0, 2'd0, 1'b1, 1'b0, 32'h2, 32'h0080_0000, 32'h0, e);
      e = '{r: 32'h0000_0080, be: 4'h0, f: 1'b0, tag: "R6 unsigned byte"};
      drive(2'd0, 2'd0, 1'b0, 1'b0, 32'h2, 32'h0080_0000, 32'h0, e);

      // R2: idle cycle lowers out_valid
      @(negedge clk);
      in_valid = 1'b0;
      @(negedge clk);
      @(negedge clk);
      check_now(out_valid === 1'b0, "R2 idle", {31'd0, out_valid}, 32'h0);

      // Full sweep against the model
      for (int p = 0; p < 2; p++) begin
         logic [31:0] rd;
         logic [31:0] mv;
         rd = p ? 32'h8C7B_E6A5 : 32'h4433_2211;
         mv = p ? 32'h1357_9BDF : 32'hDDCC_BBAA;
         for (int o = 0; o < 4; o++)
            for (int sz = 0; sz < 3; sz++)
               for (int k = 0; k < 4; k++)
                  for (int bend = 0; bend < 2; bend++)
                     for (int sg = 0; sg < 2; sg++) begin
                        e = model(2'(o), 2'(sz), 1'(sg), 1'(bend), k, rd, mv);
                        drive(2'(o), 2'(sz), 1'(sg), 1'(bend), 32'h1000 + 32'(k), rd, mv, e);
                     end
      end
      @(negedge clk);
      in_valid = 1'b0;
      repeat (3) @(negedge clk);
      check_now(q.size() == 0, "R2 all results returned", 32'(q.size()), 32'h0);
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      #2000000;
      if (!done) begin
         tests++;
         fails++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

endmodule